// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small programmable logic device. It receives the results of eight product terms from the AND array and combines them in an OR gate. Depending on its configuration, the result drives the pad through a D register or directly, with a chosen polarity. The cell also chooses the source of the pad output enable and the signal that goes back into the array as feedback. The product-term array and the configuration storage sit outside the block. The pad is modelled as three separate signals (data out, enable, data in) and not as a real tristate.

Two global configuration bits are shared by all cells. Two local bits belong to this cell only. Together they pick one of five behaviours: registered output, combinatorial I/O inside the registered family, always-driven combinatorial output, input only, and combinatorial I/O whose enable comes from a product term. A build parameter marks a cell that sits at either end of the row. Such a cell takes its neighbour-feedback decision from a different global bit than the inner cells.

Top module: `plm_macrocell`

## Requirements
- R1: The mode key is {glb_cfg[1], glb_cfg[0], loc_mux}. Key 3'b100 selects registered mode. In that mode each rising clk edge with rst low loads the register with the OR of all NTERM terms, and pad_out shows the new value from that edge on.
- R2: In registered mode pad_oe equals the inverse of the active-low pin oe_n.
- R3: In registered mode fb equals the stored register bit, whatever the value of loc_pol.
- R4: rst high at a rising clk edge clears the register to 0. In registered mode with loc_pol=0 the pad then reads 1.
- R5: In every mode other than registered, the register keeps its value across clock edges.
- R6: Keys 3'b101 and 3'b111 are the product-term-enable I/O modes. In them pad_oe equals pterm[0], pad_out is the OR of pterm[NTERM-1:1] only, and fb equals pin_in.
- R7: Key 3'b010 is the always-driven output mode. In it pad_oe is 1 and pad_out follows the OR of all terms combinatorially.
- R8: In the always-driven output mode, an inner cell (END_CELL=0) returns adj_pin on fb, because glb_cfg[1] is 0. An end cell (END_CELL=1) returns 0, because glb_cfg[0] is 1.
- R9: Key 3'b011 (input only) and the unused keys 3'b000, 3'b001 and 3'b110 give pad_oe=0 and fb=pin_in. pad_out is the OR of all terms.
- R10: loc_pol=1 passes the selected source to pad_out unchanged. loc_pol=0 inverts it. This holds in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset that clears the register to 0 |
| pterm | input | NTERM | Product-term results from the AND array |
| glb_cfg | input | 2 | Global mode bits shared by all cells |
| loc_mux | input | 1 | Local mode bit that picks the cell behaviour |
| loc_pol | input | 1 | Local polarity bit, 1 = non-inverting |
| oe_n | input | 1 | Active-low output-enable pin, used in registered mode |
| adj_pin | input | 1 | Pin value of the neighbouring cell |
| pin_in | input | 1 | Value read back from this cell's own pin |
| pad_out | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback into the product-term array |

## Verification
The assertions assume that the configuration inputs are stable during a clock cycle, and that rst is high at the first clock edges, so that the register holds a known value before any property is evaluated. The stimulus drives every input in the half cycle after a falling edge, and it holds rst high for the opening cycles. After that it draws the mode key from all eight codes, including the unused ones, and gives rst a small random chance of firing. This way the reset assertion and the hold assertion for the non-registered modes are both exercised between registered stretches.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [2:0] {
        CM_REG     = 3'd0,
        CM_REG_IO  = 3'd1,
        CM_ON      = 3'd2,
        CM_IN      = 3'd3,
        CM_PTOE_IO = 3'd4
    } cell_mode_e;

    typedef struct packed {
        logic store;
    } cell_state_t;

endpackage

// File: rtl/plm_mode_dec.sv
module plm_mode_dec
    import plm_pkg::*;
(
    input  logic [1:0]  glb_cfg,
    input  logic        loc_mux,
    output cell_mode_e  mode,
    output logic        first_is_oe,
    output logic        is_reg
);
    always_comb begin
        unique case ({glb_cfg, loc_mux})
            3'b100:  mode = CM_REG;
            3'b101:  mode = CM_REG_IO;
            3'b010:  mode = CM_ON;
            3'b011:  mode = CM_IN;
            3'b111:  mode = CM_PTOE_IO;
            default: mode = CM_IN;
        endcase
    end

    assign first_is_oe = (mode == CM_REG_IO) || (mode == CM_PTOE_IO);
    assign is_reg      = (mode == CM_REG);
endmodule

// File: rtl/plm_term_sum.sv
module plm_term_sum #(
    parameter int NTERM = 8
) (
    input  logic [NTERM-1:0] pterm,
    input  logic             mask_first,
    output logic             sum
);
    logic [NTERM-1:0] gated;

    for (genvar i = 0; i < NTERM; i++) begin : g_term
        if (i == 0) begin : g_first
            assign gated[i] = pterm[i] & ~mask_first;
        end else begin : g_rest
            assign gated[i] = pterm[i];
        end
    end

    assign sum = |gated;
endmodule

// File: rtl/plm_oe_sel.sv
module plm_oe_sel
    import plm_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       oe_n,
    input  logic       pt_first,
    output logic       pad_oe
);
    always_comb begin
        unique case (mode)
            CM_REG:     pad_oe = ~oe_n;
            CM_REG_IO:  pad_oe = pt_first;
            CM_PTOE_IO: pad_oe = pt_first;
            CM_ON:      pad_oe = 1'b1;
            default:    pad_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/plm_fb_sel.sv
module plm_fb_sel
    import plm_pkg::*;
#(
    parameter bit END_CELL = 1'b0
) (
    input  cell_mode_e mode,
    input  logic [1:0] glb_cfg,
    input  logic       store,
    input  logic       pin_in,
    input  logic       adj_pin,
    output logic       fb
);
    logic nb_block;

    if (END_CELL) begin : g_end
        assign nb_block = glb_cfg[0];
    end else begin : g_inner
        assign nb_block = glb_cfg[1];
    end

    always_comb begin
        unique case (mode)
            CM_REG:  fb = store;
            CM_ON:   fb = nb_block ? 1'b0 : adj_pin;
            default: fb = pin_in;
        endcase
    end
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
    import plm_pkg::*;
#(
    parameter int NTERM    = 8,
    parameter bit END_CELL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTERM-1:0] pterm,
    input  logic [1:0]       glb_cfg,
    input  logic             loc_mux,
    input  logic             loc_pol,
    input  logic             oe_n,
    input  logic             adj_pin,
    input  logic             pin_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             fb
);
    cell_mode_e  mode;
    logic        first_is_oe;
    logic        is_reg;
    logic        sum;
    logic        store_bit;
    logic        src;
    cell_state_t state_d, state_q;

    plm_mode_dec u_dec (
        .glb_cfg     (glb_cfg),
        .loc_mux     (loc_mux),
        .mode        (mode),
        .first_is_oe (first_is_oe),
        .is_reg      (is_reg)
    );

    plm_term_sum #(.NTERM(NTERM)) u_sum (
        .pterm      (pterm),
        .mask_first (first_is_oe),
        .sum        (sum)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.store = 1'b0;
        end else if (is_reg) begin
            state_d.store = sum;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign store_bit = state_q.store;
    assign src       = is_reg ? store_bit : sum;
    assign pad_out   = loc_pol ? src : ~src;

    plm_oe_sel u_oe (
        .mode     (mode),
        .oe_n     (oe_n),
        .pt_first (pterm[0]),
        .pad_oe   (pad_oe)
    );

    plm_fb_sel #(.END_CELL(END_CELL)) u_fb (
        .mode    (mode),
        .glb_cfg (glb_cfg),
        .store   (store_bit),
        .pin_in  (pin_in),
        .adj_pin (adj_pin),
        .fb      (fb)
    );
endmodule

// File: rtl/plm_macrocell_chk.sv
module plm_macrocell_chk #(
    parameter int NTERM = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NTERM-1:0] pterm,
    input logic [1:0]       glb_cfg,
    input logic             loc_mux,
    input logic             oe_n,
    input logic             pin_in,
    input logic             pad_oe,
    input logic             fb,
    input logic             store
);
    logic [2:0] key;
    logic       k_reg, k_ptoe, k_on, k_in;

    assign key    = {glb_cfg, loc_mux};
    assign k_reg  = (key == 3'b100);
    assign k_ptoe = (key == 3'b101) || (key == 3'b111);
    assign k_on   = (key == 3'b010);
    assign k_in   = !(k_reg || k_ptoe || k_on);

    a_r1_reg_load: assert property (@(posedge clk) disable iff (rst)
        k_reg |=> (store == $past(|pterm)));

    a_r2_reg_oe: assert property (@(posedge clk) disable iff (rst)
        k_reg |-> (pad_oe == !oe_n));

    a_r3_reg_fb: assert property (@(posedge clk) disable iff (rst)
        k_reg |-> (fb == store));

    a_r4_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (store == 1'b0));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !k_reg |=> $stable(store));

    a_r6_pt_oe: assert property (@(posedge clk) disable iff (rst)
        k_ptoe |-> (pad_oe == pterm[0] && fb == pin_in));

    a_r7_always_on: assert property (@(posedge clk) disable iff (rst)
        k_on |-> pad_oe);

    a_r9_input_only: assert property (@(posedge clk) disable iff (rst)
        k_in |-> (!pad_oe && fb == pin_in));
endmodule

bind plm_macrocell plm_macrocell_chk #(.NTERM(NTERM)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pterm   (pterm),
    .glb_cfg (glb_cfg),
    .loc_mux (loc_mux),
    .oe_n    (oe_n),
    .pin_in  (pin_in),
    .pad_oe  (pad_oe),
    .fb      (fb),
    .store   (store_bit)
);

// File: tb/sim_plm_macrocell.sv
module sim_plm_macrocell;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] pterm = '0;
    logic [1:0]    glb_cfg = 2'b10;
    logic          loc_mux = 1'b0;
    logic          loc_pol = 1'b0;
    logic          oe_n = 1'b1;
    logic          adj_pin = 1'b0;
    logic          pin_in = 1'b0;
    logic          out0, oe0, fb0, out1, oe1, fb1;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_q = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    plm_macrocell #(.NTERM(NT), .END_CELL(1'b0)) u0 (
        .clk(clk), .rst(rst), .pterm(pterm), .glb_cfg(glb_cfg),
        .loc_mux(loc_mux), .loc_pol(loc_pol), .oe_n(oe_n),
        .adj_pin(adj_pin), .pin_in(pin_in),
        .pad_out(out0), .pad_oe(oe0), .fb(fb0));

    plm_macrocell #(.NTERM(NT), .END_CELL(1'b1)) u1 (
        .clk(clk), .rst(rst), .pterm(pterm), .glb_cfg(glb_cfg),
        .loc_mux(loc_mux), .loc_pol(loc_pol), .oe_n(oe_n),
        .adj_pin(adj_pin), .pin_in(pin_in),
        .pad_out(out1), .pad_oe(oe1), .fb(fb1));

    // 0 reg, 1 product-term-enable I/O, 2 always on, 3 input only or unused
    function automatic int mode_of(logic [1:0] g, logic l);
        case ({g, l})
            3'b100:         return 0;
            3'b101, 3'b111: return 1;
            3'b010:         return 2;
            default:        return 3;
        endcase
    endfunction

    function automatic bit exp_out(int m, bit q, logic [NT-1:0] t, bit pol);
        bit s;
        if (m == 0)      s = q;
        else if (m == 1) s = |t[NT-1:1];
        else             s = |t;
        return pol ? s : ~s;
    endfunction

    function automatic bit exp_oe(int m, logic [NT-1:0] t, bit on);
        if (m == 0)      return ~on;
        else if (m == 1) return t[0];
        else if (m == 2) return 1'b1;
        else             return 1'b0;
    endfunction

    task automatic chk(bit act, bit exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (key %b%b pol %0b t %b)",
                     tag, act, exp, glb_cfg, loc_mux, loc_pol, pterm);
        end
    endtask

    task automatic check_all();
        int m;
        m = mode_of(glb_cfg, loc_mux);
        case (m)
            0: begin
                chk(out0, exp_out(m, exp_q, pterm, loc_pol), "R1/R10 reg pad_out");
                chk(oe0, exp_oe(m, pterm, oe_n), "R2 reg pad_oe");
                chk(fb0, exp_q, "R3 reg fb");
            end
            1: begin
                chk(out0, exp_out(m, exp_q, pterm, loc_pol), "R6/R10 pt-oe pad_out");
                chk(oe0, exp_oe(m, pterm, oe_n), "R6 pt-oe pad_oe");
                chk(fb0, pin_in, "R6 pt-oe fb");
            end
            2: begin
                chk(out0, exp_out(m, exp_q, pterm, loc_pol), "R7/R10 on pad_out");
                chk(oe0, 1'b1, "R7 on pad_oe");
                chk(fb0, adj_pin, "R8 inner fb");
                chk(fb1, 1'b0, "R8 end fb");
            end
            default: begin
                chk(out0, exp_out(m, exp_q, pterm, loc_pol), "R9/R10 in pad_out");
                chk(oe0, 1'b0, "R9 in pad_oe");
                chk(fb0, pin_in, "R9 in fb");
            end
        endcase
    endtask

    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        if (rst) exp_q = 1'b0;
        else if (mode_of(glb_cfg, loc_mux) == 0) exp_q = |pterm;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R4: reset clears, inverting pad reads 1
        glb_cfg = 2'b10; loc_mux = 1'b0; loc_pol = 1'b0; oe_n = 1'b0;
        #1;
        chk(out0, 1'b1, "R4 reset pad_out");
        chk(fb0, 1'b0, "R4 reset fb");
        @(negedge clk);
        rst = 1'b0;
        // R1 load one, then R5 hold across other modes
        pterm = 8'h80; step();
        pterm = 8'h00;
        glb_cfg = 2'b01; loc_mux = 1'b0; step(); step();
        glb_cfg = 2'b11; loc_mux = 1'b1; pterm = 8'h01; step();
        glb_cfg = 2'b10; loc_mux = 1'b0; pterm = 8'h00; #1;
        chk(fb0, 1'b1, "R5 held after other modes");
        step();
        chk(fb0, 1'b0, "R1 reload zero");
        // R6: only the first term set, excluded from sum
        glb_cfg = 2'b10; loc_mux = 1'b1; loc_pol = 1'b1; pterm = 8'h01; step();
        // R4: reset mid-run
        glb_cfg = 2'b10; loc_mux = 1'b0; pterm = 8'hFF; step();
        rst = 1'b1; step(); rst = 1'b0;
        // random
        for (int i = 0; i < 3000; i++) begin
            glb_cfg = 2'($urandom);
            loc_mux = 1'($urandom);
            loc_pol = 1'($urandom);
            oe_n    = 1'($urandom);
            adj_pin = 1'($urandom);
            pin_in  = 1'($urandom);
            pterm   = ($urandom % 3 == 0) ? NT'($urandom % 2) : NT'($urandom);
            rst     = ($urandom % 50 == 0);
            step();
        end
        rst = 1'b0;
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule